// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Infrared Pulse Decoding

This block turns an asynchronous serial line into parallel characters. A one-cycle enable, `tick_16x`, marks sixteen equal steps per bit time. The receiver detects the falling edge of a start bit and confirms it half a bit later. It then samples each data bit at its centre, least significant bit first. After the data come an optional parity bit and the first stop bit. Once the character is complete, the block gives a byte with parity, framing and break flags, plus a one-cycle write strobe toward a downstream receive store.

The input has two encodings. In plain mode the line level is the bit value. In infrared mode the line idles low, and a short active-high pulse means a zero bit while no pulse means a one bit. A loopback select replaces the external line with the local transmitter's serial output for self-test. When the downstream store reports full at the moment a character completes, the character is discarded and a one-cycle overrun strobe is raised instead.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `char_wr` and `char_ovr` are low, and `char_data` and all three flags are zero.
- R2: A low level seen on a tick starts a candidate start bit. It is accepted only if the line is still low 8 ticks later; otherwise the receiver returns to idle and produces nothing. Each following bit is sampled every 16 ticks after that point.
- R3: `cfg_len` selects the character length: 00 is 5 bits, 01 is 6, 10 is 7 and 11 is 8. Bits arrive LSB first, and the unused upper bits of `char_data` read zero.
- R4: With `cfg_par_en`=1, one parity bit follows the last data bit. With `cfg_par_even`=1 the data and parity bits together must hold an even count of ones; with 0, an odd count. A mismatch sets `char_perr`. With `cfg_par_en`=0, `char_perr` stays 0.
- R5: Only the first stop bit is sampled, and the character completes at its midpoint. A zero there sets `char_ferr`. A new start bit may follow directly after a single stop bit.
- R6: When start, data, parity and stop samples are all zero, `char_brk`=1, `char_ferr`=1, `char_perr`=0 and `char_data`=0. No new start bit is searched for until the line has returned high.
- R7: If `sink_full` is high in the cycle before the strobe would be issued, `char_ovr` pulses for one cycle, `char_wr` stays low and `char_data` keeps its previous value.
- R8: With `cfg_sir`=1 and `cfg_loop`=0, `rxd` is ignored. A bit reads zero when an `irx_pulse` high level was seen during the 16 ticks up to and including its sample tick.
- R9: With `cfg_loop`=1, `lb_txd` is received as a plain line, and `rxd` and `irx_pulse` are ignored.
- R10: `char_wr` is a single-cycle pulse. `char_data` and the flags change only in a `char_wr` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | External plain serial line, idle high |
| lb_txd | input | 1 | Local transmitter output used in loopback |
| irx_pulse | input | 1 | Infrared receive pulse, active high |
| cfg_len | input | 2 | Character length select |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even (1) or odd (0) parity |
| cfg_sir | input | 1 | Infrared pulse decoding select |
| cfg_loop | input | 1 | Loopback select |
| sink_full | input | 1 | Downstream store cannot accept a character |
| char_wr | output | 1 | One-cycle write strobe for a new character |
| char_data | output | 8 | Received character, right aligned |
| char_perr | output | 1 | Parity error flag |
| char_ferr | output | 1 | Framing error flag |
| char_brk | output | 1 | Break flag |
| char_ovr | output | 1 | One-cycle overrun strobe |

## Verification
The properties assume that the configuration inputs stay constant while a character is being received. The length-dependent check reads `cfg_len` at the strobe, not at the start bit. The stimulus changes the configuration only while the line is idle, and waits for each character's strobe or overrun before changing it. `tick_16x` is taken to be a single-cycle enable. The bench raises it every third clock, so the frame timing stays independent of the clock rate.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRKW
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_char_t;

    localparam int MAX_BITS = 8;

    // Shift register fills from the MSB; move the received bits to bit 0.
    function automatic logic [7:0] align_lsb(input logic [7:0] sh, input logic [1:0] len_sel);
        return sh >> (2'd3 - len_sel);
    endfunction

    function automatic logic [2:0] last_index(input logic [1:0] len_sel);
        return 3'd4 + {1'b0, len_sel};
    endfunction

endpackage

// File: rtl/uart_rx_front.sv
module uart_rx_front #(
    parameter int OSR = 16,
    localparam int CW = $clog2(OSR)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rxd,
    input  logic lb_txd,
    input  logic irx_pulse,
    input  logic cfg_sir,
    input  logic cfg_loop,
    output logic line
);
    logic [1:0]    nrz_q;
    logic [1:0]    irx_q;
    logic          hit;
    logic [CW-1:0] stretch;
    logic          nrz_src;
    logic          sir_low;

    assign nrz_src = cfg_loop ? lb_txd : rxd;
    assign sir_low = hit | irx_q[1] | (stretch != '0);
    assign line    = (cfg_sir && !cfg_loop) ? ~sir_low : nrz_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            nrz_q   <= 2'b11;
            irx_q   <= 2'b00;
            hit     <= 1'b0;
            stretch <= '0;
        end else begin
            nrz_q <= {nrz_q[0], nrz_src};
            irx_q <= {irx_q[0], irx_pulse};
            if (tick) begin
                hit <= 1'b0;
                if (hit || irx_q[1])
                    stretch <= CW'(OSR - 1);
                else if (stretch != '0)
                    stretch <= stretch - 1'b1;
            end else if (irx_q[1]) begin
                hit <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16,
    localparam int CW  = $clog2(OSR),
    localparam int MID = OSR / 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    output logic       done,
    output rx_char_t   res
);
    rx_state_e     state;
    logic [CW-1:0] cnt;
    logic [2:0]    bidx;
    logic [7:0]    sh;
    logic          allz;
    logic          parbit;
    rx_char_t      res_next;
    logic          ones_odd;

    always_comb begin
        res_next.data = align_lsb(sh, cfg_len);
        res_next.brk  = allz & ~line;
        res_next.ferr = ~line;
        ones_odd      = (^res_next.data) ^ parbit;
        res_next.perr = cfg_par_en & ~res_next.brk &
                        (cfg_par_even ? ones_odd : ~ones_odd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            bidx   <= '0;
            sh     <= '0;
            allz   <= 1'b0;
            parbit <= 1'b0;
            done   <= 1'b0;
            res    <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: if (!line) begin
                        state <= ST_START;
                        cnt   <= '0;
                    end
                    ST_START: if (cnt == CW'(MID - 1)) begin
                        cnt <= '0;
                        if (!line) begin
                            state <= ST_DATA;
                            bidx  <= '0;
                            sh    <= '0;
                            allz  <= 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    ST_DATA: if (cnt == CW'(OSR - 1)) begin
                        cnt  <= '0;
                        sh   <= {line, sh[7:1]};
                        allz <= allz & ~line;
                        if (bidx == last_index(cfg_len))
                            state <= cfg_par_en ? ST_PAR : ST_STOP;
                        else
                            bidx <= bidx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    ST_PAR: if (cnt == CW'(OSR - 1)) begin
                        cnt    <= '0;
                        parbit <= line;
                        allz   <= allz & ~line;
                        state  <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    ST_STOP: if (cnt == CW'(OSR - 1)) begin
                        cnt   <= '0;
                        done  <= 1'b1;
                        res   <= res_next;
                        state <= res_next.brk ? ST_BRKW : ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    ST_BRKW: if (line) state <= ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_16x,
    input  logic       rxd,
    input  logic       lb_txd,
    input  logic       irx_pulse,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_sir,
    input  logic       cfg_loop,
    input  logic       sink_full,
    output logic       char_wr,
    output logic [7:0] char_data,
    output logic       char_perr,
    output logic       char_ferr,
    output logic       char_brk,
    output logic       char_ovr
);
    logic     line;
    logic     eng_done;
    rx_char_t eng_res;
    rx_char_t held;

    uart_rx_front #(.OSR(OSR)) u_front (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_16x),
        .rxd       (rxd),
        .lb_txd    (lb_txd),
        .irx_pulse (irx_pulse),
        .cfg_sir   (cfg_sir),
        .cfg_loop  (cfg_loop),
        .line      (line)
    );

    uart_rx_engine #(.OSR(OSR)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick_16x),
        .line         (line),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .done         (eng_done),
        .res          (eng_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            char_wr  <= 1'b0;
            char_ovr <= 1'b0;
            held     <= '0;
        end else begin
            char_wr  <= 1'b0;
            char_ovr <= 1'b0;
            if (eng_done) begin
                if (sink_full) begin
                    char_ovr <= 1'b1;
                end else begin
                    char_wr <= 1'b1;
                    held    <= eng_res;
                end
            end
        end
    end

    assign char_data = held.data;
    assign char_perr = held.perr;
    assign char_ferr = held.ferr;
    assign char_brk  = held.brk;
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_16x,
    input logic [1:0] cfg_len,
    input logic       sink_full,
    input logic       char_wr,
    input logic [7:0] char_data,
    input logic       char_perr,
    input logic       char_ferr,
    input logic       char_brk,
    input logic       char_ovr
);
    p_wr_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        char_wr |=> !char_wr);

    p_data_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !char_wr |-> $stable(char_data) && $stable(char_ferr));

    p_wr_ovr_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(char_wr && char_ovr));

    p_full_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        char_wr |-> !$past(sink_full));

    p_ovr_needs_full_r7: assert property (@(posedge clk) disable iff (rst)
        char_ovr |-> $past(sink_full));

    p_brk_flags_r6: assert property (@(posedge clk) disable iff (rst)
        (char_wr && char_brk) |-> (char_data == 8'h00) && char_ferr && !char_perr);

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (char_wr && cfg_len == 2'b00) |-> (char_data[7:5] == 3'b000));

    p_tick_origin_r2: assert property (@(posedge clk) disable iff (rst)
        (char_wr || char_ovr) |-> $past(tick_16x, 2));
endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_16x  (tick_16x),
    .cfg_len   (cfg_len),
    .sink_full (sink_full),
    .char_wr   (char_wr),
    .char_data (char_data),
    .char_perr (char_perr),
    .char_ferr (char_ferr),
    .char_brk  (char_brk),
    .char_ovr  (char_ovr)
);

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;
    localparam int TDIV   = 3;
    localparam int BITCLK = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16x = 1'b0;
    logic       rxd = 1'b1;
    logic       lb_txd = 1'b1;
    logic       irx_pulse = 1'b0;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_sir = 1'b0;
    logic       cfg_loop = 1'b0;
    logic       sink_full = 1'b0;
    logic       char_wr, char_perr, char_ferr, char_brk, char_ovr;
    logic [7:0] char_data;

    int errors = 0;
    int checks = 0;
    logic [11:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  last_data = 8'h00;
    logic        prev_wr = 1'b0;
    bit          finished = 1'b0;

    uart_rx_core u_dut (
        .clk(clk), .rst(rst), .tick_16x(tick_16x), .rxd(rxd), .lb_txd(lb_txd),
        .irx_pulse(irx_pulse), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .cfg_sir(cfg_sir), .cfg_loop(cfg_loop),
        .sink_full(sink_full), .char_wr(char_wr), .char_data(char_data),
        .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
        .char_ovr(char_ovr)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            for (int i = 0; i < TDIV; i++) begin
                @(negedge clk);
                tick_16x = (i == 0);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference comparison each clock: every strobe must match the next queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                logic [11:0] got;
                got = {1'b0, char_brk, char_ferr, char_perr, char_data};
                if (prev_wr) check(!char_wr, "R10 strobe width", char_wr, 0);
                if (char_wr && char_ovr) check(0, "R7 wr and ovr together", 1, 0);
                if (!char_wr) check(char_data == last_data, "R10 data held", char_data, last_data);
                if (char_wr || char_ovr) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R2 unexpected character", got, 0);
                    end else begin
                        logic [11:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        if (char_ovr)
                            check(e[11] && char_data == last_data, {t, " overrun"},
                                  {char_ovr, char_data}, {e[11], last_data});
                        else
                            check(got == e, t, got, e);
                    end
                end
                if (char_wr) last_data = char_data;
                prev_wr = char_wr;
            end
        end
    end

    task automatic idle(input int bits);
        repeat (bits * BITCLK) @(negedge clk);
    endtask

    task automatic put_bit(input int sel, input logic v);
        if (sel == 0) rxd = v; else lb_txd = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic sir_bit(input logic v);
        if (!v) begin
            irx_pulse = 1'b1;
            repeat (3 * TDIV) @(negedge clk);
            irx_pulse = 1'b0;
            repeat (13 * TDIV) @(negedge clk);
        end else begin
            irx_pulse = 1'b0;
            repeat (BITCLK) @(negedge clk);
        end
    endtask

    // sel: 0 = rxd, 1 = lb_txd, 2 = infrared pulses
    task automatic send(input int sel, input logic [7:0] d, input logic bad_par,
                        input logic stopv, input int gap, input string tag);
        int n;
        logic [7:0] dm;
        logic pb;
        logic [8:0] bits;
        n  = 5 + int'(cfg_len);
        dm = d & 8'((1 << n) - 1);
        pb = (cfg_par_even ? ^dm : ~^dm) ^ bad_par;
        exp_q.push_back({sink_full, 1'b0, ~stopv, bad_par & cfg_par_en, dm});
        tag_q.push_back(tag);
        bits = {pb, dm};
        if (sel == 2) sir_bit(1'b0); else put_bit(sel, 1'b0);
        for (int i = 0; i < n; i++)
            if (sel == 2) sir_bit(bits[i]); else put_bit(sel, bits[i]);
        if (cfg_par_en) begin
            if (sel == 2) sir_bit(pb); else put_bit(sel, pb);
        end
        if (sel == 2) sir_bit(stopv); else put_bit(sel, stopv);
        if (sel == 2) sir_bit(1'b1); else if (sel == 0) rxd = 1'b1; else lb_txd = 1'b1;
        idle(gap);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!char_wr && !char_ovr && char_data == 0 && !char_perr && !char_ferr && !char_brk,
              "R1 reset state", {char_wr, char_ovr, char_data}, 0);
        idle(1);

        // R3 / R2: 8-bit characters, several patterns
        send(0, 8'hA5, 0, 1, 2, "R3 len8 A5");
        send(0, 8'h01, 0, 1, 2, "R3 len8 01");
        send(0, 8'hFE, 0, 1, 2, "R3 len8 FE");
        // R3: shorter lengths, upper bits zero
        cfg_len = 2'b00; send(0, 8'hFF, 0, 1, 2, "R3 len5");
        cfg_len = 2'b01; send(0, 8'hEA, 0, 1, 2, "R3 len6");
        cfg_len = 2'b10; send(0, 8'h55, 0, 1, 2, "R3 len7");
        // R4: parity
        cfg_len = 2'b11; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
        send(0, 8'h37, 0, 1, 2, "R4 even ok");
        send(0, 8'h37, 1, 1, 2, "R4 even bad");
        cfg_par_even = 1'b0;
        send(0, 8'h80, 0, 1, 2, "R4 odd ok");
        send(0, 8'h80, 1, 1, 2, "R4 odd bad");
        cfg_par_en = 1'b0;
        // R5: back-to-back with one stop bit, then framing error
        send(0, 8'h12, 0, 1, 0, "R5 back1");
        send(0, 8'h34, 0, 1, 0, "R5 back2");
        send(0, 8'h56, 0, 1, 2, "R5 back3");
        send(0, 8'h3C, 0, 0, 2, "R5 framing");
        // R2: false start shorter than midpoint
        rxd = 1'b0; repeat (4 * TDIV) @(negedge clk); rxd = 1'b1;
        idle(3);
        check(exp_q.size() == 0, "R2 false start ignored", exp_q.size(), 0);
        // R6: break with odd parity enabled, line low well past the character
        cfg_par_en = 1'b1;
        exp_q.push_back({1'b0, 1'b1, 1'b1, 1'b0, 8'h00});
        tag_q.push_back("R6 break");
        rxd = 1'b0; idle(14); rxd = 1'b1; idle(2);
        send(0, 8'h9D, 0, 1, 2, "R6 after break");
        cfg_par_en = 1'b0;
        // R7: overrun drops character
        sink_full = 1'b1;
        send(0, 8'h77, 0, 1, 1, "R7 dropped");
        sink_full = 1'b0;
        send(0, 8'h88, 0, 1, 2, "R7 next accepted");
        // R8: infrared decode, rxd held low and ignored
        cfg_sir = 1'b1; rxd = 1'b0; idle(1);
        send(2, 8'hC3, 0, 1, 2, "R8 sir C3");
        send(2, 8'h00, 0, 1, 2, "R8 sir 00");
        send(2, 8'h7E, 0, 1, 2, "R8 sir 7E");
        // R9: loopback overrides rxd and infrared input
        cfg_loop = 1'b1; irx_pulse = 1'b0; idle(1);
        send(1, 8'h5A, 0, 1, 2, "R9 loop 5A");
        send(1, 8'hE1, 0, 1, 2, "R9 loop E1");
        cfg_loop = 1'b0; cfg_sir = 1'b0; rxd = 1'b1;
        idle(2);
        check(exp_q.size() == 0, "R2 all characters delivered", exp_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule